// File: doc/BRIEF.md
# Burst Ready and Bus Enable Handshake

This block produces the ready strobe and the bus output enables for a memory that shares one set of pins for address and data. The host watches the ready line to learn when a burst word is on the bus, so the block has to place that strobe on the correct clock and release the shared pins whenever the chip is not selected or not being read. Each pad is modelled as a value and an enable. The drivers, the burst address counter and the latency counter sit outside this block.

In clocked (synchronous) operation, the burst engine supplies two hints. `word_due` means a valid word is on the bus in the next cycle. `word_due_la` is the same hint one cycle earlier. A configuration bit selects the ready timing. Ready can rise in the same cycle as the data, or one cycle before it. In asynchronous operation the ready value is held high. Deselecting the chip clears the ready timing register, so a burst that was cut short cannot leave a stale strobe behind.

Ready is a plain control pin and not a valid/ready stream. Nothing in this block applies back-pressure. The bus enables follow the select inputs at once and are not delayed by a clock.

Top module: `burst_rdy_handshake`

## Requirements
- R1: `rdy_oe` is 1 exactly when `ce_n` is 0 and `rst_n` is 1. Otherwise it is 0.
- R2: `dq_oe` is 1 exactly when `ce_n`, `oe_n` are both 0 and `rst_n` is 1. Whenever `dq_oe` is 1, `rdy_oe` is also 1.
- R3: While `rst_n` is 0, both enables are 0 and the ready register is cleared (asynchronous reset). After release, `rdy_o` in synchronous mode stays 0 until a hint is sampled.
- R4: With `sync_mode` = 0 (asynchronous mode), `rdy_o` is 1.
- R5: With `sync_mode` = 1 and `cfg_rdy_lead` = 0 (coincident timing), after each rising edge `rdy_o` equals the `word_due` sampled at that edge, provided `ce_n` was 0 there.
- R6: With `sync_mode` = 1 and `cfg_rdy_lead` = 1 (one-cycle lead), after each rising edge `rdy_o` equals the `word_due_la` sampled at that edge, provided `ce_n` was 0 there. `word_due` is then ignored.
- R7: A rising edge that samples `ce_n` = 1 clears the ready register. `rdy_o` in synchronous mode reads 0 after that edge, even if a hint was high.
- R8: `oe_n` has no effect on `rdy_o` or `rdy_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read output enable, active low |
| sync_mode | input | 1 | 1 = synchronous burst mode, 0 = asynchronous |
| cfg_rdy_lead | input | 1 | Ready timing: 0 = coincident with data, 1 = one cycle ahead |
| word_due | input | 1 | Burst engine: a valid word is on the bus next cycle |
| word_due_la | input | 1 | Burst engine: a valid word is on the bus in two cycles |
| rdy_o | output | 1 | Ready value |
| rdy_oe | output | 1 | Ready pad enable |
| dq_oe | output | 1 | Address/data bus output enable |

## Verification
The bench moves between the two timing settings in the middle of a stream of hints, with `word_due` and `word_due_la` set to opposite values. A design that picked the wrong hint would put ready a cycle early or late, and the two settings would then give the same result. It also drops the chip select while a hint is still high. A design that does not clear the register would show a stale ready once the chip is selected again. Further stimulus toggles the read enable without changing the select, which exposes an enable decode that mixes up the two select signals or lets `oe_n` affect ready. Stimulus in asynchronous mode with the hints held low catches a design that leaves ready on the pipeline output.

// File: rtl/burst_rdy_pkg.sv
package burst_rdy_pkg;
  typedef enum logic {
    RDY_COINCIDE = 1'b0,
    RDY_LEAD     = 1'b1
  } rdy_timing_e;

  typedef struct packed {
    logic rdy_oe;
    logic dq_oe;
  } pad_en_t;
endpackage

// File: rtl/burst_rdy_en_decode.sv
module burst_rdy_en_decode
  import burst_rdy_pkg::*;
(
  input  logic    rst_n,
  input  logic    ce_n,
  input  logic    oe_n,
  output pad_en_t en
);
  logic selected;
  assign selected  = rst_n & ~ce_n;
  assign en.rdy_oe = selected;
  assign en.dq_oe  = selected & ~oe_n;
endmodule

// File: rtl/burst_rdy_pipe.sv
module burst_rdy_pipe
  import burst_rdy_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        sync_mode,
  input  rdy_timing_e timing,
  input  logic        word_due,
  input  logic        word_due_la,
  output logic        rdy_q
);
  logic hint;
  always_comb begin
    hint = (timing == RDY_LEAD) ? word_due_la : word_due;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdy_q <= 1'b0;
    else if (ce_n)       rdy_q <= 1'b0;
    else if (!sync_mode) rdy_q <= 1'b0;
    else                 rdy_q <= hint;
  end

  p_coincide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && sync_mode && timing == RDY_COINCIDE && word_due) |=> rdy_q);
  p_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && sync_mode && timing == RDY_LEAD && word_due_la) |=> rdy_q);
  p_deselect_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !rdy_q);
endmodule

// File: rtl/burst_rdy_handshake.sv
module burst_rdy_handshake
  import burst_rdy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic sync_mode,
  input  logic cfg_rdy_lead,
  input  logic word_due,
  input  logic word_due_la,
  output logic rdy_o,
  output logic rdy_oe,
  output logic dq_oe
);
  pad_en_t     en;
  rdy_timing_e timing;
  logic        rdy_q;

  assign timing = rdy_timing_e'(cfg_rdy_lead);

  burst_rdy_en_decode u_dec (
    .rst_n (rst_n),
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .en    (en)
  );

  burst_rdy_pipe u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .sync_mode   (sync_mode),
    .timing      (timing),
    .word_due    (word_due),
    .word_due_la (word_due_la),
    .rdy_q       (rdy_q)
  );

  assign rdy_o  = sync_mode ? rdy_q : 1'b1;
  assign rdy_oe = en.rdy_oe;
  assign dq_oe  = en.dq_oe;

  p_rdy_oe_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_oe |-> !ce_n);
  p_dq_needs_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (rdy_oe && !oe_n));
  p_async_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> rdy_o);
endmodule

// File: tb/burst_rdy_handshake_tb.sv
module burst_rdy_handshake_tb;
  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, sync_mode, cfg_rdy_lead, word_due, word_due_la;
  logic rdy_o, rdy_oe, dq_oe;

  always #10 clk = ~clk;

  burst_rdy_handshake u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .sync_mode(sync_mode), .cfg_rdy_lead(cfg_rdy_lead),
    .word_due(word_due), .word_due_la(word_due_la),
    .rdy_o(rdy_o), .rdy_oe(rdy_oe), .dq_oe(dq_oe)
  );

  int    n_vec  = 0;
  int    n_fail = 0;
  logic  m_q    = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  bit    done   = 1'b0;

  // driver: apply one cycle of stimulus and push the expected outputs
  task automatic step(input logic r, input logic ce, input logic oe,
                      input logic sm, input logic ld, input logic d,
                      input logic dl, input string tag);
    @(negedge clk);
    rst_n = r; ce_n = ce; oe_n = oe; sync_mode = sm;
    cfg_rdy_lead = ld; word_due = d; word_due_la = dl;
    if (!r || ce || !sm) m_q = 1'b0;
    else                 m_q = ld ? dl : d;
    exp_q.push_back({(sm ? m_q : 1'b1), (r & ~ce), (r & ~ce & ~oe)});
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each edge, away from it
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if ({rdy_o, rdy_oe, dq_oe} !== e) begin
        n_fail++;
        $display("FAIL %s: {rdy_o,rdy_oe,dq_oe} = %b, expected %b", t, {rdy_o, rdy_oe, dq_oe}, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_vec++; n_fail++;
      $display("FAIL watchdog: done = 0, expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; sync_mode = 1'b1;
    cfg_rdy_lead = 1'b0; word_due = 1'b1; word_due_la = 1'b1;
    // R3: reset holds enables low and clears ready
    step(0, 0, 0, 1, 0, 1, 1, "R3 in reset");
    step(0, 0, 0, 1, 1, 1, 1, "R3 in reset lead");
    step(1, 1, 1, 1, 0, 0, 0, "R3 after release");
    // R1/R2: enable decode
    step(1, 1, 0, 1, 0, 0, 0, "R1 ce high oe low");
    step(1, 0, 1, 1, 0, 0, 0, "R2 ce low oe high");
    step(1, 0, 0, 1, 0, 0, 0, "R2 both low");
    // R5: coincident timing follows word_due
    step(1, 0, 0, 1, 0, 1, 0, "R5 due high");
    step(1, 0, 0, 1, 0, 1, 0, "R5 due held");
    step(1, 0, 0, 1, 0, 0, 1, "R5 lookahead ignored");
    // R6: lead timing follows word_due_la
    step(1, 0, 0, 1, 1, 0, 1, "R6 la high");
    step(1, 0, 0, 1, 1, 1, 0, "R6 due ignored");
    step(1, 0, 0, 1, 1, 0, 1, "R6 la again");
    // R7: deselect while a hint is high clears ready
    step(1, 1, 0, 1, 1, 1, 1, "R7 deselect clears");
    step(1, 0, 0, 1, 1, 0, 0, "R7 reselect no hint");
    step(1, 0, 0, 1, 0, 1, 1, "R7 new burst");
    // R8: oe_n toggling leaves ready untouched
    step(1, 0, 1, 1, 0, 1, 0, "R8 oe high ready on");
    step(1, 0, 0, 1, 0, 1, 0, "R8 oe low ready on");
    step(1, 0, 1, 1, 0, 0, 0, "R8 oe high ready off");
    // R4: asynchronous mode forces ready high
    step(1, 0, 0, 0, 0, 0, 0, "R4 async no hints");
    step(1, 0, 1, 0, 1, 0, 0, "R4 async oe high");
    step(1, 0, 0, 1, 0, 0, 0, "R4 back to sync clear");
    step(1, 1, 1, 0, 0, 0, 0, "R4 async deselected");
    // R3: reset mid-burst
    step(1, 0, 0, 1, 0, 1, 0, "R3 before reset");
    step(0, 0, 0, 1, 0, 1, 0, "R3 reset mid burst");
    step(1, 0, 0, 1, 0, 0, 0, "R3 after mid reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule